// File: doc/BRIEF.md
# 9-bit Serial Panel Command Writer

This block issues register writes to a display panel controller over a three-wire serial link that only transmits. A requester presents a command byte, a 16-bit parameter and a length code. The block expands these into a burst of 9-bit words. The first word is always the command. Zero, one or two data words follow it. Every word is prefixed with a flag bit that tells the panel whether the remaining eight bits are a command or a parameter byte.

The link runs with the clock idling high. Data is launched on falling clock edges and captured by the panel on rising edges. The serial clock is derived from the system clock by an integer ratio `DIV` (at least 2). Chip select frames the whole burst. The requester sees `busy` while a transfer is underway and a one-cycle `done` strobe when chip select is released.

Top module: `panel_cmd_writer`

## Requirements
- R1: After reset, and whenever no transfer is in progress, the outputs sit at csn=1, sck=1, sdo=0, busy=0 and done=0.
- R2: A request (req_valid=1 at a clock edge) is taken only when busy is 0. A req_valid seen while busy is 1 has no effect on the serial output or on the words sent.
- R3: Every word is 9 bits, shifted most significant bit first. Bit 8 is 0 for the command word and 1 for a data word. Bits 7:0 carry the byte.
- R4: req_len selects the data words that follow the command:
  - 0 sends none.
  - 1 sends req_param[7:0].
  - 2 sends req_param[15:8] and then req_param[7:0].
  - 3 behaves as 2.
- R5: sdo changes only in the cycle in which sck falls, or in the cycle in which csn falls. It is stable during every cycle in which sck stays high with csn low.
- R6: Each serial bit holds sck low for DIV/2 system cycles (rounded down) and then high for the remaining DIV - DIV/2 cycles. After csn falls, sck stays high for DIV - DIV/2 cycles before its first falling edge.
- R7: csn stays low without a break from acceptance until the high phase of the last bit of the last word ends. The words follow each other with no idle bits between them.
- R8: done is high for exactly one cycle, the cycle in which csn returns high. busy stays high for DIV cycles from that point, csn high throughout, and then falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_cmd | input | BYTE_W | Command or register byte |
| req_len | input | 2 | Number of data words (3 treated as 2) |
| req_param | input | 2*BYTE_W | Parameter, high byte sent first |
| busy | output | 1 | Transfer or trailing gap in progress |
| done | output | 1 | One-cycle strobe when chip select rises |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_sdo | output | 1 | Serial data out |
| spi_csn | output | 1 | Chip select, active low |

## Verification
The hardest condition to reach is a request that arrives exactly on the boundary where busy falls. A request too early is silently dropped. One edge later, it must start a fresh burst with a correct lead phase. The bench holds req_valid high across whole transfers so that every possible acceptance edge is exercised back to back. It also fires short request pulses with different data in the middle of a burst and during the trailing gap. An odd divider ratio gives unequal low and high phases, so mistakes in the phase split show up in the waveform.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } pcw_state_e;

  localparam int IDX_W = 2;
endpackage

// File: rtl/pcw_phase_timer.sv
module pcw_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/pcw_shifter.sv
module pcw_shifter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clr) sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb = sh_q[W-1];
endmodule

// File: rtl/pcw_word_sel.sv
module pcw_word_sel #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0]   cmd,
  input  logic [1:0]          len,
  input  logic [2*BYTE_W-1:0] param,
  input  logic [1:0]          idx,
  output logic [BYTE_W:0]     word,
  output logic [1:0]          last_idx
);
  logic [BYTE_W-1:0] hi_b, lo_b;
  assign hi_b = param[2*BYTE_W-1:BYTE_W];
  assign lo_b = param[BYTE_W-1:0];

  always_comb begin
    case (idx)
      2'd1:    word = {1'b1, (len == 2'd1) ? lo_b : hi_b};
      2'd2:    word = {1'b1, lo_b};
      default: word = {1'b0, cmd};
    endcase
  end

  always_comb begin
    case (len)
      2'd0:    last_idx = 2'd0;
      2'd1:    last_idx = 2'd1;
      default: last_idx = 2'd2;
    endcase
  end
endmodule

// File: rtl/panel_cmd_writer.sv
module panel_cmd_writer
  import pcw_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [BYTE_W-1:0]   req_cmd,
  input  logic [1:0]          req_len,
  input  logic [2*BYTE_W-1:0] req_param,
  output logic                busy,
  output logic                done,
  output logic                spi_sck,
  output logic                spi_sdo,
  output logic                spi_csn
);
  localparam int WORD_W = BYTE_W + 1;
  localparam int LO_CYC = DIV / 2;
  localparam int HI_CYC = DIV - LO_CYC;
  localparam int CW     = $clog2(DIV + 1);
  localparam int BC_W   = $clog2(WORD_W);
  localparam logic [CW-1:0]   LO_M1  = CW'(LO_CYC - 1);
  localparam logic [CW-1:0]   HI_M1  = CW'(HI_CYC - 1);
  localparam logic [CW-1:0]   DIV_M1 = CW'(DIV - 1);
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(WORD_W - 1);

  pcw_state_e state_q;
  logic [BYTE_W-1:0]   cmd_q;
  logic [1:0]          len_q;
  logic [2*BYTE_W-1:0] param_q;
  logic [BC_W-1:0]     bit_q;
  logic [IDX_W-1:0]    widx_q;

  logic              expire, tmr_load;
  logic [CW-1:0]     tmr_val;
  logic              sh_load, sh_shift, sh_clr;
  logic [WORD_W-1:0] sel_word, sh_din;
  logic [1:0]        last_idx;
  logic              bit_last, word_last;

  pcw_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expire(expire)
  );

  pcw_word_sel #(.BYTE_W(BYTE_W)) u_sel (
    .cmd(cmd_q), .len(len_q), .param(param_q),
    .idx(2'(widx_q + 2'd1)), .word(sel_word), .last_idx(last_idx)
  );

  pcw_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .shift(sh_shift), .clr(sh_clr),
    .din(sh_din), .msb(spi_sdo)
  );

  assign bit_last  = (bit_q == BIT_LAST);
  assign word_last = (widx_q == last_idx);
  assign sh_din    = (state_q == ST_IDLE) ? {1'b0, req_cmd} : sel_word;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_clr   = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1; tmr_val = HI_M1; sh_load = 1'b1;
      end
      ST_LEAD: if (expire) begin
        tmr_load = 1'b1; tmr_val = LO_M1;
      end
      ST_LOW: if (expire) begin
        tmr_load = 1'b1; tmr_val = HI_M1;
      end
      ST_HIGH: if (expire) begin
        tmr_load = 1'b1;
        if (bit_last && word_last) begin
          tmr_val = DIV_M1; sh_clr = 1'b1;
        end else if (bit_last) begin
          tmr_val = LO_M1; sh_load = 1'b1;
        end else begin
          tmr_val = LO_M1; sh_shift = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      spi_csn <= 1'b1;
      spi_sck <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      bit_q   <= '0;
      widx_q  <= '0;
      cmd_q   <= '0;
      len_q   <= '0;
      param_q <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          cmd_q   <= req_cmd;
          len_q   <= req_len;
          param_q <= req_param;
          bit_q   <= '0;
          widx_q  <= '0;
          spi_csn <= 1'b0;
          busy    <= 1'b1;
          state_q <= ST_LEAD;
        end
        ST_LEAD: if (expire) begin
          spi_sck <= 1'b0;
          state_q <= ST_LOW;
        end
        ST_LOW: if (expire) begin
          spi_sck <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (expire) begin
          if (bit_last) begin
            bit_q <= '0;
            if (word_last) begin
              spi_csn <= 1'b1;
              done    <= 1'b1;
              state_q <= ST_GAP;
            end else begin
              widx_q  <= widx_q + 1'b1;
              spi_sck <= 1'b0;
              state_q <= ST_LOW;
            end
          end else begin
            bit_q   <= bit_q + 1'b1;
            spi_sck <= 1'b0;
            state_q <= ST_LOW;
          end
        end
        ST_GAP: if (expire) begin
          busy    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcw_checker.sv
module pcw_checker (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic spi_sck,
  input logic spi_sdo,
  input logic spi_csn
);
  p_sck_idle_r6: assert property (@(posedge clk) disable iff (rst)
    spi_csn |-> spi_sck);

  p_sdo_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    spi_csn |-> !spi_sdo);

  p_sdo_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!spi_csn && $past(!spi_csn) && spi_sck && $past(spi_sck)) |-> $stable(spi_sdo));

  p_sel_busy_r7: assert property (@(posedge clk) disable iff (rst)
    !spi_csn |-> busy);

  p_done_at_rise_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(spi_csn));

  p_rise_gives_done_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_csn) |-> done);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_gap_kept_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_csn) |=> (spi_csn && busy));
endmodule

bind panel_cmd_writer pcw_checker u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .spi_sck(spi_sck), .spi_sdo(spi_sdo), .spi_csn(spi_csn)
);

// File: tb/sim_panel_cmd_writer.sv
module sim_panel_cmd_writer;
  localparam int DIV = 5;
  localparam int LO  = DIV / 2;
  localparam int HI  = DIV - LO;
  localparam logic [4:0] IDLE_T = 5'b01100; // busy csn sck sdo done

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [7:0]  req_cmd = '0;
  logic [1:0]  req_len = '0;
  logic [15:0] req_param = '0;
  logic busy, done, spi_sck, spi_sdo, spi_csn;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  panel_cmd_writer #(.DIV(DIV), .BYTE_W(8)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_len(req_len), .req_param(req_param), .busy(busy), .done(done),
    .spi_sck(spi_sck), .spi_sdo(spi_sdo), .spi_csn(spi_csn)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: expected output tuple per cycle
  logic [4:0] expq[$];
  logic [4:0] cur = IDLE_T;
  int exp_words[$];
  int exp_counts[$];

  function automatic void push_txn(input logic [7:0] c, input logic [1:0] l,
                                   input logic [15:0] p);
    int w[$];
    w.push_back({1'b0, c});
    if (l == 2'd1) w.push_back({1'b1, p[7:0]});
    else if (l != 2'd0) begin
      w.push_back({1'b1, p[15:8]});
      w.push_back({1'b1, p[7:0]});
    end
    exp_counts.push_back(w.size());
    foreach (w[i]) exp_words.push_back(w[i]);
    for (int k = 0; k < HI; k++) expq.push_back({4'b1010, 1'b0} | {3'b0, 1'(w[0] >> 8), 1'b0});
    foreach (w[i]) begin
      for (int b = 8; b >= 0; b--) begin
        logic bit_v;
        bit_v = 1'((w[i] >> b) & 1);
        for (int k = 0; k < LO; k++) expq.push_back({3'b100, bit_v, 1'b0});
        for (int k = 0; k < HI; k++) expq.push_back({3'b101, bit_v, 1'b0});
      end
    end
    expq.push_back(5'b11101);
    for (int k = 1; k < DIV; k++) expq.push_back(5'b11100);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      expq.delete();
    end else if (req_valid && !cur[4]) begin
      push_txn(req_cmd, req_len, req_param);
    end
  end

  // per-cycle comparison and independent word decoder
  logic prev_sck = 1'b1, prev_csn = 1'b1, prev_sdo = 1'b0;
  logic rx_bits[$];

  always @(negedge clk) begin
    if (rst) begin
      cur = IDLE_T;
    end else begin
      cur = (expq.size() > 0) ? expq.pop_front() : IDLE_T;
      check("R8 busy", busy, cur[4]);
      check("R7 csn", spi_csn, cur[3]);
      check("R6 sck", spi_sck, cur[2]);
      check("R3 sdo", spi_sdo, cur[1]);
      check("R8 done", done, cur[0]);
      // R5: data held while sck stays high inside a burst
      if (!spi_csn && !prev_csn && spi_sck && prev_sck)
        check("R5 sdo stable", spi_sdo, prev_sdo);
      if (!spi_csn && !prev_sck && spi_sck) rx_bits.push_back(spi_sdo);
      if (spi_csn && !prev_csn) begin
        int n;
        n = (exp_counts.size() > 0) ? exp_counts.pop_front() : 0;
        check("R4 bit count", rx_bits.size(), 9 * n);
        for (int i = 0; i < n; i++) begin
          int got, want;
          got = 0;
          for (int b = 0; b < 9; b++)
            if (rx_bits.size() > 0) got = (got << 1) | int'(rx_bits.pop_front());
          want = (exp_words.size() > 0) ? exp_words.pop_front() : -1;
          check("R3 decoded word", got, want);
        end
        rx_bits.delete();
      end
    end
    prev_sck = spi_sck;
    prev_csn = spi_csn;
    prev_sdo = spi_sdo;
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] c, input logic [1:0] l, input logic [15:0] p);
    req_cmd = c; req_len = l; req_param = p; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    step();
    while (busy) step();
    step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    check("R1 csn", spi_csn, 1);
    check("R1 sck", spi_sck, 1);
    check("R1 sdo", spi_sdo, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);

    send(8'h29, 2'd0, 16'h0000);   // R4 command only
    wait_idle();
    send(8'h3A, 2'd1, 16'hAA60);   // R4 one byte: low byte
    wait_idle();
    send(8'hB8, 2'd2, 16'hFFF9);   // R4 two bytes, high first
    wait_idle();
    send(8'hC3, 2'd3, 16'h2040);   // R4 length 3 acts as 2
    wait_idle();

    // R2: stray requests mid-burst and in the trailing gap are ignored
    send(8'h11, 2'd2, 16'h1234);
    repeat (20) step();
    send(8'hEE, 2'd1, 16'h00FF);
    while (!done) step();
    send(8'hDD, 2'd0, 16'h0000);
    wait_idle();
    check("R2 idle after ignored", busy, 0);

    // R2/R8: held request, accepted again right after busy drops
    req_cmd = 8'h5A; req_len = 2'd1; req_param = 16'h0081; req_valid = 1'b1;
    while (!done) step();
    while (busy) step();
    step();
    req_valid = 1'b0;
    wait_idle();

    for (int t = 0; t < 20; t++) begin
      send(8'($urandom), 2'($urandom), 16'($urandom));
      if (t % 3 == 0) wait_idle();
      else begin
        repeat (t) step();
        while (busy) step();
      end
    end
    wait_idle();
    check("R1 final idle csn", spi_csn, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule